// File: doc/BRIEF.md
# Interleaved Memory Port Steering Controller

This block sits between a synchronous processor-side request port and four memory buses. It takes one request at a time: a single word or an aligned group of four words (a quadword). It works out which memory bus and which bus-local address each word belongs to, and runs a four-phase request/acknowledge handshake on that bus. The memory buses respond in their own time, with no fixed relation to the processor clock. Read data goes back to the processor in ascending word order, and a single completion pulse closes the request.

An interleave mode is sampled when the request is accepted. The modes are four buses, two buses, or one bus, so the controller can keep working when part of the memory is out of service. The memories are assumed to lose data when read. A read therefore writes the value it fetched back to the same location before the word counts as finished. A clear/write stores new data. A read-modify-write returns the old word and keeps its bus busy until the processor supplies the replacement value, which is then written. This last operation is only legal on single words.

Top module: `memport_steer`

## Requirements
- R1: After reset, `req_ready` is 1, and `mb_req`, `rd_valid`, `req_done` and `req_refused` are all 0.
- R2: With `cfg_mode`=2'b00 (four-bus), word address a goes to bus a[1:0] at bus address a>>2.
- R3: With `cfg_mode`=2'b01 (two-bus), word address a goes to bus {0,a[0]} at bus address a>>1. Bit 1 of a becomes the lowest bus-address bit and selects the module, and buses 2 and 3 stay idle.
- R4: With `cfg_mode`=2'b10 or 2'b11 (one-bus), every word goes to bus 0 at bus address a. The words of a quadword are handled strictly one after another, so at most one bus request is active.
- R5: With `req_quad`=1, the words are addresses {a[AW-1:2],i} for i=0..3. In four-bus mode all four bus requests are active at the same time at some point.
- R6: With `req_op`=2'b00 (read/restore), each word's value is returned to the processor, and the same value is written back to the same bus location before completion.
- R7: With `req_op`=2'b01 (clear/write), word i of `req_wdata` (bits 36i+35..36i) is written to word i's location, and no read data is returned.
- R8: With `req_op`=2'b10 (read-modify-write, single word), the old value is returned. The bus then does no further access and the port does not accept a new request until `mod_valid` brings the new value. That value is then written to the same location.
- R9: A quadword request with `req_op`=2'b10 is refused with a one-cycle `req_refused` pulse. It causes no bus activity and no `req_done`.
- R10: Read data appears on `rd_data` with `rd_idx` = 0,1,2,3 in ascending order, whatever order the buses answer in. `req_done` pulses once, only after every word, including its write-back, has finished.
- R11: Each bus access is one request/acknowledge exchange. `mb_req` stays high until the 2-flop-synchronized `mb_ack` is seen high, and the next request on that bus waits until the synchronized acknowledge is low again.
- R12: `cfg_mode` is captured when the request is accepted. Changing it while the request is in flight does not change that request's routing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor-side clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_mode | input | 2 | Interleave mode: 00 four-bus, 01 two-bus, 1x one-bus |
| req_valid | input | 1 | Request strobe, taken when req_ready is high |
| req_ready | output | 1 | Controller idle and able to accept a request |
| req_op | input | 2 | 00 read/restore, 01 clear/write, 10 read-modify-write |
| req_quad | input | 1 | 1 for a quadword request, 0 for a single word |
| req_addr | input | AW | Word address |
| req_wdata | input | 4*W | Write data, word i in bits W*i+W-1..W*i |
| mod_valid | input | 1 | Modified word for a pending read-modify-write |
| mod_data | input | W | Modified word value |
| rd_valid | output | 1 | Read data strobe |
| rd_idx | output | 2 | Word index within the request of the returned data |
| rd_data | output | W | Returned read data |
| req_done | output | 1 | One-cycle completion pulse |
| req_refused | output | 1 | One-cycle pulse for a refused request |
| mb_req | output | 4 | Per-bus request |
| mb_we | output | 4 | Per-bus write (1) or read (0) |
| mb_addr | output | 4*AW | Per-bus local address, bus b in bits AW*b+AW-1..AW*b |
| mb_wdata | output | 4*W | Per-bus write data |
| mb_ack | input | 4 | Per-bus acknowledge, asynchronous |
| mb_rdata | input | 4*W | Per-bus read data, stable while acknowledge is high |

## Verification
The embedded properties watch the bus handshake on every cycle. A request only falls after the synchronized acknowledge was seen, and only rises while it is low. They also check that at most one lane is started per cycle, that buses outside the captured mode's set stay idle, that a refusal starts nothing, and that completion finds every lane idle. The data side needs the bench's scenarios: the values returned and their ascending order against out-of-order answers, the restore write leaving memory unchanged, the replacement value reaching memory after a deliberate hold, the full overlap of a four-bus quadword, and routing that ignores a mode change in flight.

// File: rtl/memsteer_pkg.sv
package memsteer_pkg;
  localparam int NBUS  = 4;
  localparam int WORDS = 4;

  typedef enum logic [1:0] {
    OP_RDRS = 2'b00,
    OP_WR   = 2'b01,
    OP_RMW  = 2'b10,
    OP_RSV  = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    MODE_FOUR = 2'b00,
    MODE_TWO  = 2'b01,
    MODE_ONE  = 2'b10,
    MODE_ONEB = 2'b11
  } mode_e;

  typedef enum logic [2:0] {
    L_IDLE, L_RREQ, L_RDROP, L_HOLD, L_WREQ, L_WDROP
  } lst_e;
endpackage

// File: rtl/memsteer_sync2.sv
module memsteer_sync2 #(
  parameter int N = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] d,
  output logic [N-1:0] q
);
  logic [N-1:0] s1, s2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1 <= '0;
      s2 <= '0;
    end else begin
      s1 <= d;
      s2 <= s1;
    end
  end

  assign q = s2;
endmodule

// File: rtl/memsteer_lane.sv
module memsteer_lane
  import memsteer_pkg::*;
#(
  parameter int W  = 36,
  parameter int AW = 22
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  op_e           st_cmd,
  input  logic [AW-1:0] st_addr,
  input  logic [W-1:0]  st_wdata,
  input  logic [1:0]    st_tag,
  input  logic          mod_hold,
  input  logic [W-1:0]  mod_q,
  input  logic          ack_async,
  input  logic [W-1:0]  rdata,
  output logic          busy,
  output logic          rd_pulse,
  output logic [1:0]    rd_tag,
  output logic [W-1:0]  rd_word,
  output logic          fin_pulse,
  output logic          bus_req,
  output logic          bus_we,
  output logic [AW-1:0] bus_addr,
  output logic [W-1:0]  bus_wdata
);
  typedef struct packed {
    lst_e          st;
    op_e           cmd;
    logic [AW-1:0] addr;
    logic [W-1:0]  wbuf;
    logic [1:0]    tag;
    logic          rdp;
    logic          finp;
  } lane_t;

  lane_t cur, nx;
  logic  ack_s;

  memsteer_sync2 #(.N(1)) u_ack_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (ack_async),
    .q    (ack_s)
  );

  always_comb begin
    nx      = cur;
    nx.rdp  = 1'b0;
    nx.finp = 1'b0;
    unique case (cur.st)
      L_IDLE: if (start) begin
        nx.cmd  = st_cmd;
        nx.addr = st_addr;
        nx.wbuf = st_wdata;
        nx.tag  = st_tag;
        nx.st   = (st_cmd == OP_WR) ? L_WREQ : L_RREQ;
      end
      L_RREQ: if (ack_s) begin
        nx.wbuf = rdata;
        nx.rdp  = 1'b1;
        nx.st   = L_RDROP;
      end
      L_RDROP: if (!ack_s) begin
        nx.st = (cur.cmd == OP_RMW) ? L_HOLD : L_WREQ;
      end
      L_HOLD: if (mod_hold) begin
        nx.wbuf = mod_q;
        nx.st   = L_WREQ;
      end
      L_WREQ: if (ack_s) nx.st = L_WDROP;
      L_WDROP: if (!ack_s) begin
        nx.finp = 1'b1;
        nx.st   = L_IDLE;
      end
      default: nx.st = L_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur <= '0;
    else        cur <= nx;
  end

  assign busy      = (cur.st != L_IDLE);
  assign bus_req   = (cur.st == L_RREQ) || (cur.st == L_WREQ);
  assign bus_we    = (cur.st == L_WREQ);
  assign bus_addr  = cur.addr;
  assign bus_wdata = cur.wbuf;
  assign rd_pulse  = cur.rdp;
  assign rd_tag    = cur.tag;
  assign rd_word   = cur.wbuf;
  assign fin_pulse = cur.finp;

  p_req_drop_after_ack_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_req) |-> $past(ack_s));

  p_req_rise_ack_low_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> !ack_s);
endmodule

// File: rtl/memsteer_seq.sv
module memsteer_seq
  import memsteer_pkg::*;
#(
  parameter int W  = 36,
  parameter int AW = 22
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic [1:0]                cfg_mode,
  input  logic                      req_valid,
  input  logic [1:0]                req_op,
  input  logic                      req_quad,
  input  logic [AW-1:0]             req_addr,
  input  logic [WORDS*W-1:0]        req_wdata,
  input  logic                      mod_valid,
  input  logic [W-1:0]              mod_data,
  input  logic [NBUS-1:0]           lane_busy,
  input  logic [NBUS-1:0]           lane_rd,
  input  logic [NBUS-1:0]           lane_fin,
  input  logic [NBUS-1:0][1:0]      lane_rd_tag,
  input  logic [NBUS-1:0][W-1:0]    lane_rd_word,
  output logic                      req_ready,
  output logic                      rd_valid,
  output logic [1:0]                rd_idx,
  output logic [W-1:0]              rd_data,
  output logic                      req_done,
  output logic                      req_refused,
  output logic [NBUS-1:0]           lane_start,
  output op_e                       st_cmd,
  output logic [AW-1:0]             st_addr,
  output logic [W-1:0]              st_wdata,
  output logic [1:0]                st_tag,
  output logic                      mod_hold,
  output logic [W-1:0]              mod_q
);
  localparam int CW = $clog2(WORDS + 1);

  typedef struct packed {
    logic                        active;
    op_e                         op;
    logic                        quad;
    mode_e                       mode;
    logic [AW-1:0]               base;
    logic [WORDS-1:0][W-1:0]     wdat;
    logic [CW-1:0]               iss;
    logic [CW-1:0]               fin;
    logic [WORDS-1:0][W-1:0]     rbuf;
    logic [WORDS-1:0]            rbit;
    logic [CW-1:0]               outp;
    logic                        rv;
    logic [1:0]                  ridx;
    logic [W-1:0]                rdat;
    logic                        done;
    logic                        refused;
    logic                        mh;
    logic [W-1:0]                md;
  } seq_t;

  seq_t          cur, nx;
  logic [CW-1:0] nwords;
  logic [AW-1:0] iss_addr;
  logic [1:0]    iss_bus;
  logic          can_issue;

  function automatic logic [1:0] pick_bus(input mode_e m, input logic [AW-1:0] a);
    case (m)
      MODE_FOUR: return a[1:0];
      MODE_TWO:  return {1'b0, a[0]};
      default:   return 2'b00;
    endcase
  endfunction

  function automatic logic [AW-1:0] pick_loc(input mode_e m, input logic [AW-1:0] a);
    case (m)
      MODE_FOUR: return a >> 2;
      MODE_TWO:  return a >> 1;
      default:   return a;
    endcase
  endfunction

  assign nwords    = cur.quad ? CW'(WORDS) : CW'(1);
  assign iss_addr  = cur.quad ? {cur.base[AW-1:2], cur.iss[1:0]} : cur.base;
  assign iss_bus   = pick_bus(cur.mode, iss_addr);
  assign can_issue = cur.active && (cur.iss < nwords) && !lane_busy[iss_bus];

  assign lane_start = can_issue ? (NBUS'(1) << iss_bus) : '0;
  assign st_cmd     = cur.op;
  assign st_addr    = pick_loc(cur.mode, iss_addr);
  assign st_wdata   = cur.wdat[cur.iss[1:0]];
  assign st_tag     = cur.iss[1:0];

  always_comb begin
    nx         = cur;
    nx.rv      = 1'b0;
    nx.done    = 1'b0;
    nx.refused = 1'b0;
    if (can_issue) nx.iss = cur.iss + CW'(1);
    nx.fin = cur.fin + CW'($countones(lane_fin));
    for (int b = 0; b < NBUS; b++) begin
      if (lane_rd[b]) begin
        nx.rbit[lane_rd_tag[b]] = 1'b1;
        nx.rbuf[lane_rd_tag[b]] = lane_rd_word[b];
      end
    end
    if (cur.active && (cur.outp < nwords) && cur.rbit[cur.outp[1:0]]) begin
      nx.rv   = 1'b1;
      nx.ridx = cur.outp[1:0];
      nx.rdat = cur.rbuf[cur.outp[1:0]];
      nx.outp = cur.outp + CW'(1);
    end
    if (cur.active && (cur.op == OP_RMW) && mod_valid && !cur.mh) begin
      nx.mh = 1'b1;
      nx.md = mod_data;
    end
    if (cur.active && (cur.fin == nwords) && ((cur.op == OP_WR) || (cur.outp == nwords))) begin
      nx.active = 1'b0;
      nx.done   = 1'b1;
      nx.mh     = 1'b0;
    end
    if (!cur.active && req_valid) begin
      if (req_quad && (op_e'(req_op) == OP_RMW)) begin
        nx.refused = 1'b1;
      end else begin
        nx.active = 1'b1;
        nx.op     = op_e'(req_op);
        nx.quad   = req_quad;
        nx.mode   = mode_e'(cfg_mode);
        nx.base   = req_addr;
        nx.wdat   = req_wdata;
        nx.iss    = '0;
        nx.fin    = '0;
        nx.rbit   = '0;
        nx.outp   = '0;
        nx.mh     = 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cur <= '0;
    else        cur <= nx;
  end

  assign req_ready   = !cur.active;
  assign rd_valid    = cur.rv;
  assign rd_idx      = cur.ridx;
  assign rd_data     = cur.rdat;
  assign req_done    = cur.done;
  assign req_refused = cur.refused;
  assign mod_hold    = cur.mh;
  assign mod_q       = cur.md;

  p_one_start_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lane_start));

  p_onebus_only_bus0_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cur.mode inside {MODE_ONE, MODE_ONEB}) |-> (lane_busy[NBUS-1:1] == '0));

  p_twobus_low_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (cur.mode == MODE_TWO) |-> (lane_busy[3:2] == 2'b00));

  p_refuse_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    req_refused |-> ((lane_start == '0) && req_ready));

  p_done_lanes_idle_r10: assert property (@(posedge clk) disable iff (!rst_n)
    req_done |-> (lane_busy == '0));
endmodule

// File: rtl/memport_steer.sv
module memport_steer
  import memsteer_pkg::*;
#(
  parameter int W  = 36,
  parameter int AW = 22
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [1:0]           cfg_mode,
  input  logic                 req_valid,
  output logic                 req_ready,
  input  logic [1:0]           req_op,
  input  logic                 req_quad,
  input  logic [AW-1:0]        req_addr,
  input  logic [WORDS*W-1:0]   req_wdata,
  input  logic                 mod_valid,
  input  logic [W-1:0]         mod_data,
  output logic                 rd_valid,
  output logic [1:0]           rd_idx,
  output logic [W-1:0]         rd_data,
  output logic                 req_done,
  output logic                 req_refused,
  output logic [NBUS-1:0]      mb_req,
  output logic [NBUS-1:0]      mb_we,
  output logic [NBUS*AW-1:0]   mb_addr,
  output logic [NBUS*W-1:0]    mb_wdata,
  input  logic [NBUS-1:0]      mb_ack,
  input  logic [NBUS*W-1:0]    mb_rdata
);
  logic [1:0]              rst_pipe;
  logic                    rst_core;
  logic [NBUS-1:0]         lane_start, lane_busy, lane_rd, lane_fin;
  logic [NBUS-1:0][1:0]    lane_rd_tag;
  logic [NBUS-1:0][W-1:0]  lane_rd_word;
  op_e                     st_cmd;
  logic [AW-1:0]           st_addr;
  logic [W-1:0]            st_wdata;
  logic [1:0]              st_tag;
  logic                    mod_hold;
  logic [W-1:0]            mod_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core = rst_pipe[1];

  memsteer_seq #(.W(W), .AW(AW)) u_seq (
    .clk         (clk),
    .rst_n       (rst_core),
    .cfg_mode    (cfg_mode),
    .req_valid   (req_valid),
    .req_op      (req_op),
    .req_quad    (req_quad),
    .req_addr    (req_addr),
    .req_wdata   (req_wdata),
    .mod_valid   (mod_valid),
    .mod_data    (mod_data),
    .lane_busy   (lane_busy),
    .lane_rd     (lane_rd),
    .lane_fin    (lane_fin),
    .lane_rd_tag (lane_rd_tag),
    .lane_rd_word(lane_rd_word),
    .req_ready   (req_ready),
    .rd_valid    (rd_valid),
    .rd_idx      (rd_idx),
    .rd_data     (rd_data),
    .req_done    (req_done),
    .req_refused (req_refused),
    .lane_start  (lane_start),
    .st_cmd      (st_cmd),
    .st_addr     (st_addr),
    .st_wdata    (st_wdata),
    .st_tag      (st_tag),
    .mod_hold    (mod_hold),
    .mod_q       (mod_q)
  );

  for (genvar g = 0; g < NBUS; g++) begin : g_lane
    memsteer_lane #(.W(W), .AW(AW)) u_lane (
      .clk      (clk),
      .rst_n    (rst_core),
      .start    (lane_start[g]),
      .st_cmd   (st_cmd),
      .st_addr  (st_addr),
      .st_wdata (st_wdata),
      .st_tag   (st_tag),
      .mod_hold (mod_hold),
      .mod_q    (mod_q),
      .ack_async(mb_ack[g]),
      .rdata    (mb_rdata[g*W +: W]),
      .busy     (lane_busy[g]),
      .rd_pulse (lane_rd[g]),
      .rd_tag   (lane_rd_tag[g]),
      .rd_word  (lane_rd_word[g]),
      .fin_pulse(lane_fin[g]),
      .bus_req  (mb_req[g]),
      .bus_we   (mb_we[g]),
      .bus_addr (mb_addr[g*AW +: AW]),
      .bus_wdata(mb_wdata[g*W +: W])
    );
  end
endmodule

// File: tb/sim_memport_steer.sv
module sim_memport_steer;
  localparam int CLK_PERIOD = 10;
  localparam int W  = 36;
  localparam int AW = 22;

  // vector: [15:14] mode, [13:12] op, [11] quad, [10:3] addr, [2:0] expected peak of active bus requests
  localparam int NV = 9;
  localparam logic [15:0] VEC [NV] = '{
    {2'b00, 2'b00, 1'b1, 8'h15, 3'd4},
    {2'b00, 2'b00, 1'b0, 8'h27, 3'd1},
    {2'b01, 2'b00, 1'b1, 8'h0A, 3'd2},
    {2'b10, 2'b00, 1'b1, 8'h21, 3'd1},
    {2'b00, 2'b01, 1'b1, 8'h30, 3'd4},
    {2'b01, 2'b01, 1'b0, 8'h07, 3'd1},
    {2'b00, 2'b10, 1'b0, 8'h2E, 3'd1},
    {2'b10, 2'b10, 1'b0, 8'h05, 3'd1},
    {2'b11, 2'b01, 1'b1, 8'h3C, 3'd1}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [1:0]        cfg_mode = 2'b00;
  logic              req_valid = 1'b0;
  logic              req_ready;
  logic [1:0]        req_op = 2'b00;
  logic              req_quad = 1'b0;
  logic [AW-1:0]     req_addr = '0;
  logic [4*W-1:0]    req_wdata = '0;
  logic              mod_valid = 1'b0;
  logic [W-1:0]      mod_data = '0;
  logic              rd_valid;
  logic [1:0]        rd_idx;
  logic [W-1:0]      rd_data;
  logic              req_done, req_refused;
  logic [3:0]        mb_req, mb_we, mb_ack;
  logic [4*AW-1:0]   mb_addr;
  logic [4*W-1:0]    mb_wdata, mb_rdata;

  logic              ack_b [4];
  logic [W-1:0]      rd_b  [4];
  logic [W-1:0]      mem [4][64];
  int                acc_cnt, n_rd, maxfl, n_done, n_ref, n_tests, n_fail, cyc;
  logic [1:0]        got_idx  [4];
  logic [W-1:0]      got_data [4];

  assign mb_ack   = {ack_b[3], ack_b[2], ack_b[1], ack_b[0]};
  assign mb_rdata = {rd_b[3], rd_b[2], rd_b[1], rd_b[0]};

  memport_steer #(.W(W), .AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .req_valid(req_valid),
    .req_ready(req_ready), .req_op(req_op), .req_quad(req_quad),
    .req_addr(req_addr), .req_wdata(req_wdata), .mod_valid(mod_valid),
    .mod_data(mod_data), .rd_valid(rd_valid), .rd_idx(rd_idx),
    .rd_data(rd_data), .req_done(req_done), .req_refused(req_refused),
    .mb_req(mb_req), .mb_we(mb_we), .mb_addr(mb_addr), .mb_wdata(mb_wdata),
    .mb_ack(mb_ack), .mb_rdata(mb_rdata)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // destructive-read memory responders, slower on lower bus numbers
  for (genvar g = 0; g < 4; g++) begin : g_resp
    initial begin
      logic [5:0] loc;
      ack_b[g] = 1'b0;
      rd_b[g]  = '0;
      forever begin
        @(posedge clk);
        if (mb_req[g] && !ack_b[g]) begin
          loc = mb_addr[g*AW +: 6];
          #(2 + (3 - g) * 7);
          if (mb_we[g]) mem[g][loc] = mb_wdata[g*W +: W];
          else begin
            rd_b[g] = mem[g][loc];
            mem[g][loc] = '0;
          end
          acc_cnt++;
          ack_b[g] = 1'b1;
          wait (!mb_req[g]);
          #3;
          ack_b[g] = 1'b0;
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rd_valid) begin
      if (n_rd < 4) begin
        got_idx[n_rd]  = rd_idx;
        got_data[n_rd] = rd_data;
      end
      n_rd++;
    end
    if ($countones(mb_req) > maxfl) maxfl = $countones(mb_req);
    if (req_done) n_done++;
    if (req_refused) n_ref++;
  end

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog (all requirements): actual %0d cycles expected completion", cyc);
      summary();
      $finish;
    end
  end

  task automatic chk(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  function automatic logic [1:0] mapb(input logic [1:0] m, input logic [7:0] a);
    case (m)
      2'b00:   return a[1:0];
      2'b01:   return {1'b0, a[0]};
      default: return 2'b00;
    endcase
  endfunction

  function automatic logic [5:0] mapl(input logic [1:0] m, input logic [7:0] a);
    case (m)
      2'b00:   return 6'(a >> 2);
      2'b01:   return 6'(a >> 1);
      default: return 6'(a);
    endcase
  endfunction

  function automatic logic [W-1:0] pat(input logic [1:0] b, input logic [5:0] l);
    return 36'hA50000000 + 36'(b) * 36'd256 + 36'(l);
  endfunction

  task automatic run_vec(input logic [1:0] mode, input logic [1:0] op, input logic quad,
                         input logic [7:0] addr, input int exp_fl, input bit flip, input string rq);
    int           n, base_done, wait_c;
    bit           sent;
    logic [1:0]   b [4];
    logic [5:0]   l [4];
    logic [W-1:0] wd [4];
    logic [7:0]   a;
    n = quad ? 4 : 1;
    for (int i = 0; i < 4; i++) begin
      a = quad ? {addr[7:2], 2'(i)} : addr;
      b[i] = mapb(mode, a);
      l[i] = mapl(mode, a);
      wd[i] = 36'h3C0000000 + 36'(i * 17) + 36'(addr);
    end
    for (int bb = 0; bb < 4; bb++)
      for (int ll = 0; ll < 64; ll++) mem[bb][ll] = pat(2'(bb), 6'(ll));
    acc_cnt = 0; n_rd = 0; maxfl = 0; base_done = n_done;
    @(negedge clk);
    cfg_mode = mode; req_op = op; req_quad = quad; req_addr = AW'(addr);
    req_wdata = {wd[3], wd[2], wd[1], wd[0]}; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (flip) cfg_mode = 2'b10;
    sent = 1'b0; wait_c = 0;
    while (n_done == base_done && wait_c < 2000) begin
      @(negedge clk); #1;
      wait_c++;
      if (op == 2'b10 && n_rd == 1 && !sent) begin
        chk("R8", "port busy while modify pending", 64'(req_ready), 64'd0);
        repeat (10) @(negedge clk);
        #1;
        chk("R8", "no bus access during hold", 64'(acc_cnt), 64'd1);
        chk("R8", "location emptied by read", 64'(mem[b[0]][l[0]]), 64'd0);
        mod_data = got_data[0] + 36'd1; mod_valid = 1'b1;
        @(negedge clk); #1;
        mod_valid = 1'b0; sent = 1'b1;
      end
    end
    chk("R10", "single completion pulse", 64'(n_done - base_done), 64'd1);
    if (op == 2'b01) chk("R7", "no read data on write", 64'(n_rd), 64'd0);
    else begin
      chk("R10", "read word count", 64'(n_rd), 64'(n));
      for (int i = 0; i < n; i++) begin
        chk("R10", "ascending index", 64'(got_idx[i]), 64'(i));
        chk(rq, "read data routing", 64'(got_data[i]), 64'(pat(b[i], l[i])));
      end
    end
    for (int i = 0; i < n; i++) begin
      if (op == 2'b00) chk("R6", "restored location", 64'(mem[b[i]][l[i]]), 64'(pat(b[i], l[i])));
      else if (op == 2'b01) chk("R7", "written location", 64'(mem[b[i]][l[i]]), 64'(wd[i]));
      else chk("R8", "modified location", 64'(mem[b[i]][l[i]]), 64'(pat(b[i], l[i]) + 36'd1));
    end
    chk("R11", "bus exchanges", 64'(acc_cnt), 64'((op == 2'b01) ? n : 2 * n));
    chk((exp_fl == 4) ? "R5" : rq, "peak concurrent bus requests", 64'(maxfl), 64'(exp_fl));
  endtask

  initial begin
    int base_done;
    n_tests = 0; n_fail = 0; cyc = 0; acc_cnt = 0; n_rd = 0; maxfl = 0; n_done = 0; n_ref = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1", "req_ready after reset", 64'(req_ready), 64'd1);
    chk("R1", "mb_req after reset", 64'(mb_req), 64'd0);
    chk("R1", "rd_valid after reset", 64'(rd_valid), 64'd0);
    chk("R1", "req_done after reset", 64'(req_done), 64'd0);
    chk("R1", "req_refused after reset", 64'(req_refused), 64'd0);

    for (int v = 0; v < NV; v++)
      run_vec(VEC[v][15:14], VEC[v][13:12], VEC[v][11], VEC[v][10:3], int'(VEC[v][2:0]), 1'b0,
              (VEC[v][15:14] == 2'b00) ? "R2" : (VEC[v][15:14] == 2'b01) ? "R3" : "R4");

    // R12: mode change after acceptance leaves routing unchanged
    run_vec(2'b00, 2'b00, 1'b1, 8'h08, 4, 1'b1, "R12");

    // R9: quadword read-modify-write is refused
    acc_cnt = 0; maxfl = 0; n_ref = 0; base_done = n_done;
    @(negedge clk);
    cfg_mode = 2'b00; req_op = 2'b10; req_quad = 1'b1; req_addr = AW'(8'h10); req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (40) @(negedge clk);
    chk("R9", "refusal pulses", 64'(n_ref), 64'd1);
    chk("R9", "bus activity", 64'(acc_cnt), 64'd0);
    chk("R9", "peak bus requests", 64'(maxfl), 64'd0);
    chk("R9", "no completion", 64'(n_done - base_done), 64'd0);
    chk("R9", "port idle after refusal", 64'(req_ready), 64'd1);

    summary();
    $finish;
  end
endmodule